// File: doc/BRIEF.md
# LRU Stack Replacement Tracker

This block keeps the recency order of the pages that occupy a fixed set of page frames, and it names the page to evict when a new page needs a frame. The order is held in a hardware stack of page numbers. The top slot holds the most recently used page and the bottom occupied slot holds the least recently used one. An occupancy count records how many slots are filled.

Each clock cycle can carry one reference, which is a strobe together with a page number. A page that is already in the stack is a hit. It is pulled out of its slot and placed on top, and the entries that were above it each move down one slot. A page that is not in the stack is a miss. If a frame is still free, the page is pushed on top and nothing is evicted. If every frame is full, the bottom entry is reported as the victim, everything shifts down, and the new page goes on top. The surrounding memory manager uses the result to decide which frame to refill.

Top module: `lru_stack_tracker`

## Requirements
- R1: After reset the stack is empty: `hit`, `victim_valid` and `victim_page` are all 0, and no page counts as present.
- R2: The result of a reference appears on the outputs on the first clock edge after `ref_valid` is sampled high, and it holds until the next accepted reference.
- R3: A reference is a hit (`hit`=1) exactly when its page is one of the occupied stack entries; otherwise `hit`=0.
- R4: On a hit, the page moves to the top. The entries that were above it shift down one place and the entries below it keep their places, so a page that was hit is evicted later than pages that have not been used since.
- R5: On a miss while fewer than `NUM_FRAMES` slots are filled, the page is pushed on top and the occupancy grows by one. `victim_valid` is 0 and `victim_page` is 0.
- R6: On a miss while all slots are filled, `victim_valid` is 1 and `victim_page` is the least recently used page (the bottom entry). The new page takes the top and the occupancy stays at `NUM_FRAMES`.
- R7: With 3 frames, the reference sequence 7, 0, 1, 2, 0, 3, 0, 4 evicts 7, then 1, then 2, on the references to 2, 3 and 4.
- R8: A cycle with `ref_valid` low changes neither the outputs nor the stored order.
- R9: A repeated reference to the page already on top is a hit and leaves the order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; empties the stack |
| ref_valid | input | 1 | A page reference is present this cycle |
| ref_page | input | PAGE_W | Page number of the reference |
| hit | output | 1 | Last reference found its page in the stack |
| victim_valid | output | 1 | Last reference evicted a page |
| victim_page | output | PAGE_W | Page evicted by the last reference, 0 if none |

## Verification
The hardest case to reach is a hit on an entry in the middle or at the bottom of a full stack that is immediately followed by a miss. Only in that case does a wrong shift boundary show up, as a wrong victim one reference later. The bench sweeps every six-reference sequence over four page values (spread across the page-number range) from reset, so that every combination of hit position, fill level and eviction occurs. A last-use timestamp model independently predicts each hit and victim. Directed sequences cover the given eviction string, repeated references to the top page, and idle cycles between references.

// File: rtl/lru_pkg.sv
`timescale 1ns/1ps
package lru_pkg;
    parameter int unsigned LRU_FRAMES = 3;
    parameter int unsigned LRU_PAGE_W = 4;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lru_match.sv
`timescale 1ns/1ps
// Compares the key against every occupied slot and encodes the matching slot index.
module lru_match #(
    parameter int unsigned NUM_FRAMES = 3,
    parameter int unsigned PAGE_W     = 4,
    parameter int unsigned CNT_W      = 2,
    parameter int unsigned IDX_W      = 2
) (
    input  logic [NUM_FRAMES-1:0][PAGE_W-1:0] slots,
    input  logic [CNT_W-1:0]                  fill,
    input  logic [PAGE_W-1:0]                 key,
    output logic [NUM_FRAMES-1:0]             match_vec,
    output logic                              found,
    output logic [IDX_W-1:0]                  match_idx
);
    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_cmp
        assign match_vec[i] = (CNT_W'(i) < fill) && (slots[i] == key);
    end

    always_comb begin
        match_idx = '0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (match_vec[i]) match_idx = IDX_W'(i);
        end
    end

    assign found = |match_vec;
endmodule

// File: rtl/lru_shift.sv
`timescale 1ns/1ps
// Moves the key to slot 0; slots 1..limit take their upper neighbour, the rest hold.
module lru_shift #(
    parameter int unsigned NUM_FRAMES = 3,
    parameter int unsigned PAGE_W     = 4,
    parameter int unsigned IDX_W      = 2
) (
    input  logic [NUM_FRAMES-1:0][PAGE_W-1:0] slots,
    input  logic [PAGE_W-1:0]                 key,
    input  logic [IDX_W-1:0]                  limit,
    output logic [NUM_FRAMES-1:0][PAGE_W-1:0] slots_next
);
    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_slot
        if (i == 0) begin : g_top
            assign slots_next[i] = key;
        end else begin : g_rest
            assign slots_next[i] = (IDX_W'(i) <= limit) ? slots[i-1] : slots[i];
        end
    end
endmodule

// File: rtl/lru_stack_tracker.sv
`timescale 1ns/1ps
module lru_stack_tracker
    import lru_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = LRU_FRAMES,
    parameter int unsigned PAGE_W     = LRU_PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_valid,
    input  logic [PAGE_W-1:0] ref_page,
    output logic              hit,
    output logic              victim_valid,
    output logic [PAGE_W-1:0] victim_page
);
    localparam int unsigned CNT_W = $clog2(NUM_FRAMES + 1);
    localparam int unsigned IDX_W = idx_width(NUM_FRAMES);

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        page_t [NUM_FRAMES-1:0] slot;      // slot[0] = most recent
        logic  [CNT_W-1:0]      fill;
        logic                   hit;
        logic                   vic_vld;
        page_t                  vic_page;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_FRAMES-1:0]             match_vec;
    logic                              found;
    logic [IDX_W-1:0]                  match_idx;
    logic [IDX_W-1:0]                  shift_lim;
    logic [NUM_FRAMES-1:0][PAGE_W-1:0] slots_shifted;
    logic                              full;

    lru_match #(
        .NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_match (
        .slots    (st_q.slot),
        .fill     (st_q.fill),
        .key      (ref_page),
        .match_vec(match_vec),
        .found    (found),
        .match_idx(match_idx)
    );

    assign full      = (st_q.fill == CNT_W'(NUM_FRAMES));
    assign shift_lim = found ? match_idx : IDX_W'(NUM_FRAMES - 1);

    lru_shift #(
        .NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
    ) u_shift (
        .slots     (st_q.slot),
        .key       (ref_page),
        .limit     (shift_lim),
        .slots_next(slots_shifted)
    );

    always_comb begin
        st_d = st_q;
        if (ref_valid) begin
            st_d.slot     = slots_shifted;
            st_d.hit      = found;
            st_d.vic_vld  = !found && full;
            st_d.vic_page = (!found && full) ? st_q.slot[NUM_FRAMES-1] : '0;
            if (!found && !full) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit          = st_q.hit;
    assign victim_valid = st_q.vic_vld;
    assign victim_page  = st_q.vic_page;

    // R3: at most one occupied slot can match a page
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R5: occupancy never exceeds the frame count
    a_r5_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= CNT_W'(NUM_FRAMES));

    // R5: a miss with free frames grows occupancy by one and evicts nothing
    a_r5_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !found && !full) |=>
            (st_q.fill == $past(st_q.fill) + 1'b1) && !victim_valid);

    // R6: an eviction only happens with every frame occupied
    a_r6_evict_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (st_q.fill == CNT_W'(NUM_FRAMES)));

    // R4: the referenced page ends up on top
    a_r4_ref_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> (st_q.slot[0] == $past(ref_page)));

    // R8: idle cycles leave all state untouched
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |=> $stable(st_q));
endmodule

// File: tb/lru_stack_tracker_tb.sv
`timescale 1ns/1ps
module lru_stack_tracker_tb;
    localparam int N  = 3;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [PW-1:0] ref_page = '0;
    logic          hit;
    logic          victim_valid;
    logic [PW-1:0] victim_page;

    int checks = 0;
    int errors = 0;

    int m_pg [N];
    int m_ts [N];
    int m_fill;
    int m_time;

    int last_vp;

    always #2.5 clk = ~clk;

    lru_stack_tracker #(.NUM_FRAMES(N), .PAGE_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page),
        .hit(hit), .victim_valid(victim_valid), .victim_page(victim_page)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Timestamp model: victim is the present page with the oldest last use.
    task automatic model_ref(input int p, output bit e_hit, output bit e_vv, output int e_vp);
        e_hit = 0; e_vv = 0; e_vp = 0;
        m_time++;
        for (int i = 0; i < m_fill; i++) begin
            if (m_pg[i] == p) begin e_hit = 1; m_ts[i] = m_time; end
        end
        if (!e_hit) begin
            if (m_fill < N) begin
                m_pg[m_fill] = p; m_ts[m_fill] = m_time; m_fill++;
            end else begin
                int k = 0;
                for (int i = 1; i < N; i++) if (m_ts[i] < m_ts[k]) k = i;
                e_vv = 1; e_vp = m_pg[k];
                m_pg[k] = p; m_ts[k] = m_time;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_fill = 0; m_time = 0;
        for (int i = 0; i < N; i++) begin m_pg[i] = 0; m_ts[i] = 0; end
    endtask

    // Drive at a negedge, sample at the next negedge (one register stage).
    task automatic do_ref(input int p, input string tag);
        bit e_hit, e_vv; int e_vp;
        model_ref(p, e_hit, e_vv, e_vp);
        ref_valid = 1'b1; ref_page = PW'(p);
        @(negedge clk);
        ref_valid = 1'b0;
        check({"R3 hit ", tag}, int'(hit), int'(e_hit));
        check(e_vv ? {"R6 victim_valid ", tag} : {"R5 victim_valid ", tag}, int'(victim_valid), int'(e_vv));
        check(e_vv ? {"R6 victim_page ", tag} : {"R5 victim_page ", tag}, int'(victim_page), e_vp);
        last_vp = e_vp;
    endtask

    task automatic idle_check(input string tag);
        logic h0, v0; logic [PW-1:0] p0;
        h0 = hit; v0 = victim_valid; p0 = victim_page;
        ref_page = ~ref_page;
        @(negedge clk);
        check({"R8 idle hit ", tag}, int'(hit), int'(h0));
        check({"R2 hold victim_valid ", tag}, int'(victim_valid), int'(v0));
        check({"R8 idle victim_page ", tag}, int'(victim_page), int'(p0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 hit after reset", int'(hit), 0);
        check("R1 victim_valid after reset", int'(victim_valid), 0);
        check("R1 victim_page after reset", int'(victim_page), 0);

        // R7: given sequence with three frames
        begin
            int seq [8] = '{7, 0, 1, 2, 0, 3, 0, 4};
            int exp_v [8] = '{-1, -1, -1, 7, -1, 1, -1, 2};
            for (int i = 0; i < 8; i++) begin
                do_ref(seq[i], "R7 seq");
                if (exp_v[i] >= 0) begin
                    check("R7 victim_valid", int'(victim_valid), 1);
                    check("R7 victim_page", int'(victim_page), exp_v[i]);
                end
            end
        end
        idle_check("after R7");

        // R1: reset empties the stack; former pages miss
        do_reset();
        check("R1 victim_valid cleared", int'(victim_valid), 0);
        do_ref(4, "R1 post-reset");
        check("R1 former page misses", int'(hit), 0);

        // R4: a hit on the bottom entry protects it from the next eviction
        do_reset();
        do_ref(1, "R4"); do_ref(2, "R4"); do_ref(3, "R4");
        do_ref(1, "R4");
        check("R4 bottom hit", int'(hit), 1);
        do_ref(9, "R4");
        check("R4 victim after reorder", int'(victim_page), 2);

        // R9: repeated reference to the top page
        do_reset();
        do_ref(3, "R9"); do_ref(3, "R9");
        check("R9 top rehit", int'(hit), 1);
        do_ref(3, "R9");
        do_ref(5, "R9"); do_ref(6, "R9"); do_ref(3, "R9"); do_ref(3, "R9");
        do_ref(8, "R9");
        check("R9 victim order unchanged", int'(victim_page), 5);

        // Sweep: all length-6 strings over pages {0,5,10,15}
        for (int s = 0; s < 4096; s++) begin
            do_reset();
            for (int k = 0; k < 6; k++) begin
                do_ref(((s >> (2 * k)) & 3) * 5, "sweep");
            end
            if ((s % 64) == 0) idle_check("sweep");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule